// File: doc/BRIEF.md
# Audio Clock Ratio and Rate Monitor

This block watches the two clocks of a serial audio port, the bit clock and the frame sync, from a free-running reference clock. For every frame it counts bit-clock rising edges between consecutive frame starts (frame-sync rising edges) and the reference cycles that make up the frame period. The bit count is mapped onto a small set of legal bit-per-frame ratios. The period is mapped onto five sample-rate families, with two base rates in each family (the 48 kHz and 44.1 kHz series) and a window of plus or minus 2 percent around each base rate.

Committed status (ratio code, rate code) drives a clock-fault flag. The flag steers a gain ramp. A fault walks the playback gain down to zero in fixed steps. Once the clocks are good again, the gain walks back to the requested volume. A software bit selects automatic rate detection or a manually configured rate. A separate output tells downstream processing when the stream runs in the 192 kHz family, which is processed internally at half rate.

Top module: `aclk_monitor`

## Requirements
- R1: Committed bit-clock edge counts per frame of 64, 96, 128, 192, 256, 384 and 512 report ratio codes 0x4, 0x5, 0x6, 0x7, 0x8, 0x9 and 0xA respectively.
- R2: Any other count per frame reports ratio code 0xF, and `clk_fault` is 1 while that code is shown.
- R3: Frame periods within 2 percent of a base rate report 3'b001 (16 kHz family), 3'b011 (32 kHz), 3'b100 (48 kHz), 3'b101 (96 kHz) or 3'b110 (192 kHz). A period outside every window reports 3'b000 in automatic mode and raises `clk_fault`.
- R4: With `auto_rate_dis`=0, `rate_code` shows the measured rate. With `auto_rate_dis`=1, it shows `cfg_rate`, and `clk_fault` is 1 whenever the measured rate differs from `cfg_rate`.
- R5: A new ratio or rate is committed only after two consecutive complete frames measure the same values. After reset, or after a timeout, the first frame start only arms the measurement.
- R6: If no frame start arrives for TIMEOUT reference cycles, the status becomes ratio 0xF and rate 3'b000, with `clk_fault` 1.
- R7: While `clk_fault` is 1, `gain` falls by RAMP_STEP (floored at 0) once every STEP_FRAMES frame ends or timeouts, and never rises. The gain never changes by more than RAMP_STEP in one cycle.
- R8: While `clk_fault` is 0, `gain` moves toward `target_vol` by RAMP_STEP per step and lands exactly on it, both upward and downward.
- R9: A fault arriving partway through an upward ramp reverses the ramp at once. Recovery ramps up again from wherever the gain stands.
- R10: `downsample_req` is 1 exactly when `rate_code` is 3'b110.
- R11: After reset, the outputs are ratio 0xF, rate 3'b000, `clk_fault` 1, `gain` 0 and `downsample_req` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sbclk | input | 1 | Serial bit clock, asynchronous to clk_ref |
| fsync | input | 1 | Frame sync; a rising edge starts a frame |
| auto_rate_dis | input | 1 | 0: automatic rate detection, 1: manual rate |
| cfg_rate | input | 3 | Configured rate code used in manual mode |
| target_vol | input | VOL_W | Volume the gain ramps to when clocks are valid |
| ratio_code | output | 4 | Committed bits-per-frame code |
| rate_code | output | 3 | Reported rate family code |
| clk_fault | output | 1 | Clock fault flag |
| downsample_req | output | 1 | Stream is in the 192 kHz family |
| gain | output | VOL_W | Ramped playback gain |

## Verification
A wrong counter or classifier shows up as a wrong ratio or rate code on the third frame start after a clock change. A broken agreement stage shows up one frame early or never. A ramp fault shows up as a gain that overshoots the target, rises during a fault, or stalls. These become visible within STEP_FRAMES frames of the event. A lost timeout path leaves the stale status on the ports indefinitely once the frame sync stops.

// File: rtl/aclk_mon_pkg.sv
package aclk_mon_pkg;

  localparam int RATIO_W = 10;

  localparam logic [3:0] RATIO_ERR = 4'hF;

  localparam logic [2:0] RATE_NONE = 3'b000;
  localparam logic [2:0] RATE_16K  = 3'b001;
  localparam logic [2:0] RATE_32K  = 3'b011;
  localparam logic [2:0] RATE_48K  = 3'b100;
  localparam logic [2:0] RATE_96K  = 3'b101;
  localparam logic [2:0] RATE_192K = 3'b110;

  // Map a bit-clock count per frame onto its legal ratio code.
  function automatic logic [3:0] ratio_encode(input logic [RATIO_W-1:0] n);
    case (n)
      10'd64:  return 4'h4;
      10'd96:  return 4'h5;
      10'd128: return 4'h6;
      10'd192: return 4'h7;
      10'd256: return 4'h8;
      10'd384: return 4'h9;
      10'd512: return 4'hA;
      default: return RATIO_ERR;
    endcase
  endfunction

endpackage

// File: rtl/aclk_edge_sync.sv
module aclk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);

  logic [STAGES:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-1:0], async_in};
  end

  assign rise = shreg[STAGES-1] & ~shreg[STAGES];

endmodule

// File: rtl/aclk_frame_meter.sv
module aclk_frame_meter
  import aclk_mon_pkg::*;
#(
  parameter int unsigned REF_HZ  = 98_304_000,
  parameter int unsigned TIMEOUT = 8192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sb_rise,
  input  logic       fs_rise,
  output logic [3:0] ratio_st,
  output logic [2:0] rate_st,
  output logic       tick
);

  localparam int PW   = $clog2(TIMEOUT + 1);
  localparam int NWIN = 10;
  localparam int unsigned FS_HZ [NWIN] = '{16000, 14700, 32000, 29400, 48000,
                                           44100, 96000, 88200, 192000, 176400};
  localparam logic [2:0] FAM [NWIN] = '{RATE_16K, RATE_16K, RATE_32K, RATE_32K,
                                        RATE_48K, RATE_48K, RATE_96K, RATE_96K,
                                        RATE_192K, RATE_192K};

  logic [RATIO_W-1:0] rcnt_q, rcnt_d;
  logic [PW-1:0]      pcnt_q, pcnt_d;
  logic               armed_q, armed_d, pv_q, pv_d;
  logic [3:0]         pratio_q, pratio_d, sratio_q, sratio_d;
  logic [2:0]         prate_q, prate_d, srate_q, srate_d;
  logic [NWIN-1:0]    hit;
  logic [2:0]         meas_rate;
  logic [3:0]         meas_ratio;
  logic               timeout;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    localparam int unsigned NOM = REF_HZ / FS_HZ[g];
    localparam logic [PW-1:0] LO = PW'(NOM - NOM / 50);
    localparam logic [PW-1:0] HI = PW'(NOM + NOM / 50);
    assign hit[g] = (pcnt_q >= LO) && (pcnt_q <= HI);
  end

  always_comb begin
    meas_rate = RATE_NONE;
    for (int i = 0; i < NWIN; i++)
      if (hit[i]) meas_rate = FAM[i];
  end

  assign meas_ratio = ratio_encode(rcnt_q);
  assign timeout    = (pcnt_q >= PW'(TIMEOUT));

  always_comb begin
    rcnt_d   = rcnt_q;
    pcnt_d   = pcnt_q + 1'b1;
    armed_d  = armed_q;
    pv_d     = pv_q;
    pratio_d = pratio_q;
    prate_d  = prate_q;
    sratio_d = sratio_q;
    srate_d  = srate_q;
    if (fs_rise)                  rcnt_d = sb_rise ? RATIO_W'(1) : '0;
    else if (sb_rise && rcnt_q != '1) rcnt_d = rcnt_q + 1'b1;
    if (fs_rise || timeout) pcnt_d = PW'(1);
    if (timeout) begin
      armed_d  = 1'b0;
      pv_d     = 1'b0;
      sratio_d = RATIO_ERR;
      srate_d  = RATE_NONE;
    end else if (fs_rise) begin
      armed_d = 1'b1;
      if (armed_q) begin
        pratio_d = meas_ratio;
        prate_d  = meas_rate;
        pv_d     = 1'b1;
        if (pv_q && meas_ratio == pratio_q && meas_rate == prate_q) begin
          sratio_d = meas_ratio;
          srate_d  = meas_rate;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt_q   <= '0;
      pcnt_q   <= PW'(1);
      armed_q  <= 1'b0;
      pv_q     <= 1'b0;
      pratio_q <= RATIO_ERR;
      prate_q  <= RATE_NONE;
      sratio_q <= RATIO_ERR;
      srate_q  <= RATE_NONE;
    end else begin
      rcnt_q   <= rcnt_d;
      pcnt_q   <= pcnt_d;
      armed_q  <= armed_d;
      pv_q     <= pv_d;
      pratio_q <= pratio_d;
      prate_q  <= prate_d;
      sratio_q <= sratio_d;
      srate_q  <= srate_d;
    end
  end

  assign ratio_st = sratio_q;
  assign rate_st  = srate_q;
  assign tick     = timeout || (fs_rise && armed_q);

endmodule

// File: rtl/aclk_gain_ramp.sv
module aclk_gain_ramp #(
  parameter int VOL_W       = 8,
  parameter int RAMP_STEP   = 8,
  parameter int STEP_FRAMES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             fault,
  input  logic [VOL_W-1:0] target,
  output logic [VOL_W-1:0] gain
);

  localparam int FW = $clog2(STEP_FRAMES + 1);
  localparam logic [VOL_W-1:0] STEP = VOL_W'(RAMP_STEP);
  localparam logic [FW-1:0]    LAST = FW'(STEP_FRAMES - 1);

  logic [FW-1:0]    fcnt_q, fcnt_d;
  logic [VOL_W-1:0] gain_q, gain_d;
  logic             step_now;

  assign step_now = tick && (fcnt_q == LAST);

  always_comb begin
    fcnt_d = fcnt_q;
    gain_d = gain_q;
    if (tick) fcnt_d = step_now ? '0 : fcnt_q + 1'b1;
    if (step_now) begin
      if (fault)
        gain_d = (gain_q > STEP) ? gain_q - STEP : '0;
      else if (gain_q < target)
        gain_d = (target - gain_q > STEP) ? gain_q + STEP : target;
      else if (gain_q > target)
        gain_d = (gain_q - target > STEP) ? gain_q - STEP : target;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt_q <= '0;
      gain_q <= '0;
    end else begin
      fcnt_q <= fcnt_d;
      gain_q <= gain_d;
    end
  end

  assign gain = gain_q;

endmodule

// File: rtl/aclk_monitor.sv
module aclk_monitor
  import aclk_mon_pkg::*;
#(
  parameter int unsigned REF_HZ      = 98_304_000,
  parameter int unsigned TIMEOUT     = 8192,
  parameter int          SYNC_STAGES = 2,
  parameter int          VOL_W       = 8,
  parameter int          RAMP_STEP   = 8,
  parameter int          STEP_FRAMES = 4
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             sbclk,
  input  logic             fsync,
  input  logic             auto_rate_dis,
  input  logic [2:0]       cfg_rate,
  input  logic [VOL_W-1:0] target_vol,
  output logic [3:0]       ratio_code,
  output logic [2:0]       rate_code,
  output logic             clk_fault,
  output logic             downsample_req,
  output logic [VOL_W-1:0] gain
);

  logic sb_rise, fs_rise, tick;
  logic [2:0] rate_st;

  aclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sb_sync (
    .clk(clk_ref), .rst_n(rst_n), .async_in(sbclk), .rise(sb_rise));

  aclk_edge_sync #(.STAGES(SYNC_STAGES)) u_fs_sync (
    .clk(clk_ref), .rst_n(rst_n), .async_in(fsync), .rise(fs_rise));

  aclk_frame_meter #(.REF_HZ(REF_HZ), .TIMEOUT(TIMEOUT)) u_meter (
    .clk(clk_ref), .rst_n(rst_n), .sb_rise(sb_rise), .fs_rise(fs_rise),
    .ratio_st(ratio_code), .rate_st(rate_st), .tick(tick));

  assign clk_fault = (ratio_code == RATIO_ERR) || (rate_st == RATE_NONE) ||
                     (auto_rate_dis && (rate_st != cfg_rate));
  assign rate_code      = auto_rate_dis ? cfg_rate : rate_st;
  assign downsample_req = (rate_code == RATE_192K);

  aclk_gain_ramp #(.VOL_W(VOL_W), .RAMP_STEP(RAMP_STEP),
                   .STEP_FRAMES(STEP_FRAMES)) u_ramp (
    .clk(clk_ref), .rst_n(rst_n), .tick(tick), .fault(clk_fault),
    .target(target_vol), .gain(gain));

endmodule

// File: rtl/aclk_monitor_chk.sv
module aclk_monitor_chk #(
  parameter int VOL_W     = 8,
  parameter int RAMP_STEP = 8
) (
  input logic             clk_ref,
  input logic             rst_n,
  input logic             auto_rate_dis,
  input logic [VOL_W-1:0] target_vol,
  input logic [3:0]       ratio_code,
  input logic [2:0]       rate_code,
  input logic             clk_fault,
  input logic [VOL_W-1:0] gain
);

  localparam logic [VOL_W-1:0] STEP = VOL_W'(RAMP_STEP);

  // R1
  ratio_legal_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (ratio_code == 4'hF) || (ratio_code >= 4'h4 && ratio_code <= 4'hA));

  // R2
  ratio_err_fault_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (ratio_code == 4'hF) |-> clk_fault);

  // R3
  rate_none_fault_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (!auto_rate_dis && rate_code == 3'b000) |-> clk_fault);

  // R3
  rate_legal_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !auto_rate_dis |-> (rate_code inside {3'b000, 3'b001, 3'b011, 3'b100, 3'b101, 3'b110}));

  // R7
  gain_step_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (gain >= $past(gain)) ? (gain - $past(gain) <= STEP) : ($past(gain) - gain <= STEP));

  // R7
  fault_no_rise_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    clk_fault |=> (gain <= $past(gain)));

  // R8
  no_overshoot_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !clk_fault |=> (gain <= $past(gain) || gain <= $past(target_vol)));

endmodule

bind aclk_monitor aclk_monitor_chk #(.VOL_W(VOL_W), .RAMP_STEP(RAMP_STEP)) u_chk (
  .clk_ref(clk_ref), .rst_n(rst_n), .auto_rate_dis(auto_rate_dis),
  .target_vol(target_vol), .ratio_code(ratio_code), .rate_code(rate_code),
  .clk_fault(clk_fault), .gain(gain));

// File: tb/aclk_monitor_tb.sv
module aclk_monitor_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sbclk = 1'b0;
  logic       fsync = 1'b0;
  logic       auto_rate_dis = 1'b0;
  logic [2:0] cfg_rate = 3'b100;
  logic [7:0] target_vol = 8'd0;
  logic [3:0] ratio_code;
  logic [2:0] rate_code;
  logic       clk_fault, downsample_req;
  logic [7:0] gain;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  aclk_monitor u_dut (
    .clk_ref(clk), .rst_n(rst_n), .sbclk(sbclk), .fsync(fsync),
    .auto_rate_dis(auto_rate_dis), .cfg_rate(cfg_rate), .target_vol(target_vol),
    .ratio_code(ratio_code), .rate_code(rate_code), .clk_fault(clk_fault),
    .downsample_req(downsample_req), .gain(gain));

  typedef struct packed {
    logic [9:0] ratio;
    logic [4:0] half;
    logic       man;
    logic [2:0] cfg;
    logic [3:0] xratio;
    logic [2:0] xrate;
    logic       xfault;
  } vec_t;

  // Frame period = ratio * 2 * half reference cycles at 98.304 MHz nominal.
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{10'd64,  5'd4,  1'b0, 3'd4, 4'h4, 3'b110, 1'b0},
    '{10'd96,  5'd16, 1'b0, 3'd4, 4'h5, 3'b011, 1'b0},
    '{10'd128, 5'd2,  1'b0, 3'd4, 4'h6, 3'b110, 1'b0},
    '{10'd192, 5'd8,  1'b0, 3'd4, 4'h7, 3'b011, 1'b0},
    '{10'd256, 5'd4,  1'b0, 3'd4, 4'h8, 3'b100, 1'b0},
    '{10'd384, 5'd4,  1'b0, 3'd4, 4'h9, 3'b011, 1'b0},
    '{10'd512, 5'd2,  1'b0, 3'd4, 4'hA, 3'b100, 1'b0},
    '{10'd256, 5'd2,  1'b0, 3'd4, 4'h8, 3'b101, 1'b0},
    '{10'd192, 5'd16, 1'b0, 3'd4, 4'h7, 3'b001, 1'b0},
    '{10'd32,  5'd8,  1'b0, 3'd4, 4'hF, 3'b110, 1'b1},
    '{10'd64,  5'd5,  1'b0, 3'd4, 4'h4, 3'b000, 1'b1},
    '{10'd256, 5'd4,  1'b1, 3'd4, 4'h8, 3'b100, 1'b0},
    '{10'd256, 5'd4,  1'b1, 3'd5, 4'h8, 3'b101, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_true(input string req, input bit cond, input int act, input int exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic frames(input int ratio, input int half, input int n);
    for (int f = 0; f < n; f++)
      for (int b = 0; b < ratio; b++) begin
        fsync = (b < ratio / 2);
        sbclk = 1'b0;
        repeat (half) @(negedge clk);
        sbclk = 1'b1;
        repeat (half) @(negedge clk);
      end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    int g1, g2, g3;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 ratio", ratio_code, 15);
    chk("R11 rate", rate_code, 0);
    chk("R11 fault", clk_fault, 1);
    chk("R11 gain", gain, 0);
    chk("R11 flag", downsample_req, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 after reset: two frames are not enough to commit
    frames(64, 4, 2);
    chk("R5 no early commit", ratio_code, 15);
    frames(64, 4, 1);
    chk("R5 commit on third start", ratio_code, 4);

    // R1 R2 R3 R4 R10: vector table
    for (int i = 0; i < NV; i++) begin
      auto_rate_dis = VECS[i].man;
      cfg_rate = VECS[i].cfg;
      frames(VECS[i].ratio, VECS[i].half, 3);
      chk($sformatf("R1/R2 ratio vec%0d", i), ratio_code, VECS[i].xratio);
      chk($sformatf("R3/R4 rate vec%0d", i), rate_code, VECS[i].xrate);
      chk($sformatf("R2/R3/R4 fault vec%0d", i), clk_fault, VECS[i].xfault);
      chk($sformatf("R10 flag vec%0d", i), downsample_req, VECS[i].xrate == 3'b110);
    end
    auto_rate_dis = 1'b0;
    cfg_rate = 3'b100;

    // R8 ramp up then down to a lower target
    target_vol = 8'd40;
    frames(64, 4, 30);
    chk("R8 reach target up", gain, 40);
    target_vol = 8'd24;
    frames(64, 4, 12);
    chk("R8 reach target down", gain, 24);

    // R9 reversal partway through an upward ramp
    target_vol = 8'd200;
    frames(64, 4, 8);
    g1 = gain;
    chk_true("R9 ramping up", g1 > 24 && g1 < 200, g1, 40);
    frames(32, 8, 3);
    g2 = gain;
    chk("R2 fault on bad ratio", clk_fault, 1);
    frames(32, 8, 8);
    g3 = gain;
    chk_true("R9 reversed", g3 < g2 && g3 < g1, g3, g2 - 16);
    frames(32, 8, 30);
    chk("R7 gain floored at zero", gain, 0);

    // R9 recovery from zero
    target_vol = 8'd40;
    frames(64, 4, 30);
    chk("R9 recovered", gain, 40);
    chk("R9 fault cleared", clk_fault, 0);

    // R6 missing frame sync
    sbclk = 1'b0;
    fsync = 1'b0;
    repeat (9000) @(negedge clk);
    chk("R6 ratio", ratio_code, 15);
    chk("R6 rate", rate_code, 0);
    chk("R6 fault", clk_fault, 1);

    // R5 change needs two agreeing frames
    frames(64, 4, 3);
    chk("R5 rearmed", ratio_code, 4);
    frames(256, 4, 2);
    chk("R5 old ratio kept", ratio_code, 4);
    chk("R5 old rate kept", rate_code, 6);
    frames(256, 4, 1);
    chk("R5 new ratio", ratio_code, 8);
    chk("R5 new rate", rate_code, 4);

    done = 1;
    summary();
  end

endmodule